// File: doc/BRIEF.md
# Pixel Format Repacking Unit

This unit sits between a 32-bit pixel word queue and a serial display transmitter. Each accepted word holds pixel bytes in one of eight memory layouts: padded 32-bit, packed 24-bit or 16-bit. The unit recovers the red, green and blue components of every pixel and sends them out one byte at a time, in either a two-byte 5-6-5 form or a three-byte 8-8-8 form. The 8-8-8 form also serves 18-bit panels.

A frame begins with a start pulse while the unit is idle. The pulse fixes the input layout, the output form and the pixel count for the whole frame. Words arrive on a valid/ready input and bytes leave on a valid/ready output. Bytes that are left over go into a small byte stage and are kept across word boundaries, so a packed 24-bit pixel may span two words. The final byte of the frame carries a last flag. Any padding that remains in the current word after the final pixel is dropped.

Top module: `pix_repack`

## Requirements
- R1: After reset, word_ready, byte_valid and byte_last are all low.
- R2: A start pulse while idle with a nonzero pix_count latches in_fmt, out_fmt and pix_count for the frame. A start pulse during a frame has no effect, and neither do later changes to in_fmt, out_fmt or pix_count. A start pulse with pix_count of 0 begins nothing.
- R3: Memory byte k of a word is bits [8k+7:8k], and byte 0 comes first. For in_fmt 0, 1, 2 and 3, each word is one pixel. The bytes are, in memory order: 0 = R,G,B,pad; 1 = B,G,R,pad; 2 = pad,R,G,B; 3 = pad,B,G,R.
- R4: in_fmt 4 is packed R,G,B and in_fmt 5 is packed B,G,R, at three bytes per pixel with no padding. A pixel may span two words, and no byte is lost or repeated.
- R5: in_fmt 6 and 7 carry two pixels per word, and the lower halfword is the earlier pixel. Within a halfword, in_fmt 7 holds R in [15:11], G in [10:5] and B in [4:0]. in_fmt 6 holds B in [15:11], G in [10:5] and R in [4:0]. Each field is widened to 8 bits by appending its own top bits: {r5,r5[4:2]} and {g6,g6[5:4]}.
- R6: With out_fmt 0, each pixel is sent as two bytes. The first is {R[7:3],G[7:5]} and the second is {G[4:2],B[7:3]}.
- R7: With out_fmt 1, each pixel is sent as three bytes: R, then G, then B.
- R8: A frame of N pixels produces exactly 2N or 3N bytes. byte_last is high on the final byte only.
- R9: After the final pixel, the unit drops the rest of the current word and keeps word_ready low until the next start. The next frame begins with an empty byte stage.
- R10: While byte_valid is high and byte_ready is low, byte_data and byte_last do not change.
- R11: If words are always offered and bytes are always accepted, no cycle without a valid byte occurs between the first and the last byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame when idle |
| in_fmt | input | 3 | Input memory layout code (0..7) |
| out_fmt | input | 1 | 0 = two-byte 5-6-5, 1 = three-byte 8-8-8 |
| pix_count | input | CNT_W | Number of pixels in the frame |
| word_valid | input | 1 | Input word offered |
| word_data | input | 32 | Input word, memory byte 0 in bits [7:0] |
| word_ready | output | 1 | Unit accepts the word this cycle |
| byte_valid | output | 1 | Output byte offered |
| byte_data | output | 8 | Output byte |
| byte_last | output | 1 | Final byte of the frame |
| byte_ready | input | 1 | Consumer accepts the byte this cycle |

## Verification
The unit has no fixed latency: a word taken at one clock edge is in the stage after that edge. The pixel is extracted at the next edge, and its first byte is valid after it. The following bytes then come one per accepted cycle. The bench therefore follows the handshakes instead of counting a set number of cycles. It drives and samples at the falling edge, and it records a transfer whenever valid and ready are both high there, because that transfer takes place at the next rising edge. The expected byte stream and the position of the last flag are worked out in advance from the layout rules. The only timing check that counts cycles is the gap-free run: under full flow, the last byte must appear exactly 2N-1 or 3N-1 cycles after the first.

// File: rtl/pix_repack.sv
module pix_repack #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       in_fmt,
  input  logic             out_fmt,
  input  logic [CNT_W-1:0] pix_count,
  input  logic             word_valid,
  input  logic [31:0]      word_data,
  output logic             word_ready,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             byte_last,
  input  logic             byte_ready
);

  logic             active;
  logic [2:0]       ifmt;
  logic             ofmt;
  logic [CNT_W-1:0] left;
  logic [63:0]      stage;
  logic [3:0]       scnt;
  logic [23:0]      obuf;
  logic [1:0]       ocnt;
  logic             olast;

  logic [3:0]  bpp;
  logic        busy, go, take, send, ext, fin;
  logic [7:0]  s0, s1, s2, s3, r, g, b;
  logic [15:0] hw;
  logic [23:0] packed_px;

  assign bpp = ifmt[2] ? (ifmt[1] ? 4'd2 : 4'd3) : 4'd4;
  assign busy = active || (ocnt != 2'd0);
  assign go = start && !busy && (pix_count != '0);
  assign word_ready = active && (scnt < bpp);
  assign take = word_valid && word_ready;
  assign byte_valid = ocnt != 2'd0;
  assign byte_data = obuf[23:16];
  assign byte_last = olast && (ocnt == 2'd1);
  assign send = byte_valid && byte_ready;
  assign ext = active && (scnt >= bpp) && ((ocnt == 2'd0) || ((ocnt == 2'd1) && byte_ready));
  assign fin = left == CNT_W'(1);

  assign {s3, s2, s1, s0} = stage[31:0];
  assign hw = {s1, s0};

  always_comb begin
    r = s0; g = s1; b = s2;
    case (ifmt)
      3'd1, 3'd5: begin b = s0; g = s1; r = s2; end
      3'd2:       begin r = s1; g = s2; b = s3; end
      3'd3:       begin b = s1; g = s2; r = s3; end
      3'd6: begin
        b = {hw[15:11], hw[15:13]};
        g = {hw[10:5], hw[10:9]};
        r = {hw[4:0], hw[4:2]};
      end
      3'd7: begin
        r = {hw[15:11], hw[15:13]};
        g = {hw[10:5], hw[10:9]};
        b = {hw[4:0], hw[4:2]};
      end
      default: begin r = s0; g = s1; b = s2; end
    endcase
  end

  assign packed_px = ofmt ? {r, g, b} : {r[7:3], g[7:5], g[4:2], b[7:3], 8'h00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ifmt   <= 3'd0;
      ofmt   <= 1'b0;
      left   <= '0;
      stage  <= '0;
      scnt   <= 4'd0;
    end else if (go) begin
      active <= 1'b1;
      ifmt   <= in_fmt;
      ofmt   <= out_fmt;
      left   <= pix_count;
      stage  <= '0;
      scnt   <= 4'd0;
    end else if (take) begin
      stage <= stage | ({32'b0, word_data} << {scnt, 3'b000});
      scnt  <= scnt + 4'd4;
    end else if (ext) begin
      left <= left - CNT_W'(1);
      if (fin) begin
        active <= 1'b0;
        stage  <= '0;
        scnt   <= 4'd0;
      end else begin
        stage <= stage >> {bpp, 3'b000};
        scnt  <= scnt - bpp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obuf  <= '0;
      ocnt  <= 2'd0;
      olast <= 1'b0;
    end else if (ext) begin
      obuf  <= packed_px;
      ocnt  <= ofmt ? 2'd3 : 2'd2;
      olast <= fin;
    end else if (send) begin
      obuf <= {obuf[15:0], 8'h00};
      ocnt <= ocnt - 2'd1;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data) && $stable(byte_last));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (pix_count != '0) |=> word_ready);

  assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    send && byte_last |=> !word_ready && !byte_valid);

  assert_last_frame_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    send && byte_last |-> !active && (left == '0));

  assert_stage_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= 4'd6);

  assert_short_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ofmt |-> ocnt != 2'd3);

endmodule

// File: tb/sim_pix_repack.sv
module sim_pix_repack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  in_fmt = 3'd0;
  logic        out_fmt = 1'b0;
  logic [23:0] pix_count = '0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_last;
  logic        byte_ready = 1'b0;

  always #5 clk = ~clk;

  pix_repack #(.CNT_W(24)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_fmt(in_fmt), .out_fmt(out_fmt),
    .pix_count(pix_count), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_last(byte_last), .byte_ready(byte_ready)
  );

  // in_fmt, out_fmt, npix, seed, word-valid pattern, byte-ready pattern
  localparam logic [23:0] VEC [16] = '{
    {3'd0, 1'b0, 4'd3, 8'd11,  4'hF, 4'hF},
    {3'd0, 1'b1, 4'd2, 8'd23,  4'hA, 4'hF},
    {3'd1, 1'b1, 4'd3, 8'd35,  4'hF, 4'h5},
    {3'd1, 1'b0, 4'd2, 8'd47,  4'hB, 4'hE},
    {3'd2, 1'b0, 4'd3, 8'd59,  4'hF, 4'hF},
    {3'd2, 1'b1, 4'd2, 8'd71,  4'h7, 4'hD},
    {3'd3, 1'b1, 4'd3, 8'd83,  4'hF, 4'hF},
    {3'd3, 1'b0, 4'd4, 8'd95,  4'hE, 4'hB},
    {3'd4, 1'b1, 4'd5, 8'd107, 4'hF, 4'hF},
    {3'd4, 1'b0, 4'd4, 8'd119, 4'h5, 4'hF},
    {3'd5, 1'b1, 4'd7, 8'd131, 4'hF, 4'h9},
    {3'd5, 1'b0, 4'd1, 8'd143, 4'hF, 4'hF},
    {3'd6, 1'b0, 4'd3, 8'd155, 4'hF, 4'hF},
    {3'd6, 1'b1, 4'd4, 8'd167, 4'hD, 4'h7},
    {3'd7, 1'b0, 4'd5, 8'd179, 4'hF, 4'hF},
    {3'd7, 1'b1, 4'd2, 8'd191, 4'h3, 4'hC}
  };

  int nchk = 0;
  int nfail = 0;
  bit timeout = 1'b0;
  logic [7:0] mem [64];
  logic [7:0] exp_d [64];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] membyte(input logic [7:0] seed, input int k);
    int v;
    v = int'(seed) + k * 29 + k * k;
    return v[7:0];
  endfunction

  task automatic run_frame(input logic [2:0] fi, input logic fo, input int np,
                           input logic [7:0] seed, input logic [3:0] vm,
                           input logic [3:0] rm, input bit gap);
    int bpp, nw, nexp;
    int idx, cyc1, got, cyc2, first_c, last_c;
    bit fired, stalled;
    logic [7:0] sd;
    logic sl;
    string tag;
    bpp = (fi < 4) ? 4 : ((fi < 6) ? 3 : 2);
    tag = (fi < 4) ? "R3" : ((fi < 6) ? "R4" : "R5");
    tag = {tag, fo ? "/R7" : "/R6"};
    for (int k = 0; k < 64; k++) mem[k] = membyte(seed, k);
    nexp = 0;
    for (int p = 0; p < np; p++) begin
      logic [7:0] r, g, b;
      logic [15:0] hw;
      int a;
      a = p * bpp;
      hw = {mem[a+1], mem[a]};
      r = mem[a]; g = mem[a+1]; b = mem[a+2];
      case (fi)
        3'd1, 3'd5: begin b = mem[a]; g = mem[a+1]; r = mem[a+2]; end
        3'd2: begin r = mem[a+1]; g = mem[a+2]; b = mem[a+3]; end
        3'd3: begin b = mem[a+1]; g = mem[a+2]; r = mem[a+3]; end
        3'd6: begin
          b = {hw[15:11], hw[15:13]}; g = {hw[10:5], hw[10:9]}; r = {hw[4:0], hw[4:2]};
        end
        3'd7: begin
          r = {hw[15:11], hw[15:13]}; g = {hw[10:5], hw[10:9]}; b = {hw[4:0], hw[4:2]};
        end
        default: ;
      endcase
      if (fo) begin
        exp_d[nexp] = r; exp_d[nexp+1] = g; exp_d[nexp+2] = b;
        nexp += 3;
      end else begin
        exp_d[nexp] = {r[7:3], g[7:5]};
        exp_d[nexp+1] = {g[4:2], b[7:3]};
        nexp += 2;
      end
    end
    nw = (np * bpp + 3) / 4;

    @(negedge clk); #1;
    in_fmt = fi; out_fmt = fo; pix_count = 24'(np); start = 1'b1;
    @(negedge clk); #1;
    in_fmt = ~fi; out_fmt = ~fo; pix_count = 24'd9;   // R2: ignored mid-frame
    @(negedge clk); #1;
    start = 1'b0;

    fork
      begin
        idx = 0; fired = 1'b0; cyc1 = 0;
        while (idx < nw && !timeout) begin
          @(negedge clk); #1;
          if (fired) idx++;
          if (idx < nw) begin
            word_valid = vm[cyc1 % 4];
            word_data = {mem[4*idx+3], mem[4*idx+2], mem[4*idx+1], mem[4*idx]};
          end else begin
            word_valid = 1'b0;
          end
          fired = word_valid && word_ready;
          cyc1++;
        end
        word_valid = 1'b0;
      end
      begin
        got = 0; cyc2 = 0; stalled = 1'b0; first_c = 0; last_c = 0; sd = '0; sl = 1'b0;
        while (got < nexp && !timeout) begin
          @(negedge clk); #1;
          if (stalled)
            check(byte_valid && byte_data == sd && byte_last == sl, "R10",
                  "held byte", int'(byte_data), int'(sd));
          byte_ready = rm[cyc2 % 4];
          stalled = byte_valid && !byte_ready;
          sd = byte_data; sl = byte_last;
          if (byte_valid && byte_ready) begin
            check(byte_data == exp_d[got], tag, $sformatf("byte %0d", got),
                  int'(byte_data), int'(exp_d[got]));
            check(byte_last == (got == nexp - 1), "R8", $sformatf("last flag byte %0d", got),
                  int'(byte_last), int'(got == nexp - 1));
            if (got == 0) first_c = cyc2;
            last_c = cyc2;
            got++;
          end
          cyc2++;
        end
        byte_ready = 1'b1;
        if (gap)
          check(last_c - first_c == nexp - 1, "R11", "cycles first to last byte",
                last_c - first_c, nexp - 1);
      end
    join

    word_valid = 1'b1;
    word_data = 32'hFFFF_FFFF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check(!word_ready && !byte_valid, "R9", "idle after frame",
            int'({word_ready, byte_valid}), 0);
    end
    word_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    timeout = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(!word_ready && !byte_valid && !byte_last, "R1", "reset outputs",
          int'({word_ready, byte_valid, byte_last}), 0);

    pix_count = 24'd0; start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    @(negedge clk); #1;
    check(!word_ready && !byte_valid, "R2", "zero count start",
          int'({word_ready, byte_valid}), 0);

    foreach (VEC[i]) begin
      if (!timeout)
        run_frame(VEC[i][23:21], VEC[i][20], int'(VEC[i][19:16]), VEC[i][15:8],
                  VEC[i][7:4], VEC[i][3:0], 1'b0);
    end

    if (!timeout) run_frame(3'd0, 1'b1, 4, 8'd201, 4'hF, 4'hF, 1'b1);
    if (!timeout) run_frame(3'd4, 1'b0, 6, 8'd213, 4'hF, 4'hF, 1'b1);
    if (!timeout) run_frame(3'd6, 1'b1, 5, 8'd225, 4'hF, 4'hF, 1'b1);
    if (!timeout) run_frame(3'd6, 1'b0, 1, 8'd237, 4'hF, 4'hF, 1'b0);
    if (!timeout) run_frame(3'd7, 1'b0, 2, 8'd249, 4'hF, 4'hF, 1'b0);

    if (timeout) check(1'b0, "R8", "watchdog expired", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule